// File: doc/BRIEF.md
# Multi-Mode Operand Address Unit

This block executes one register-memory add at a time. The source operand can come from any of ten addressing modes. An instruction arrives as a 4-bit mode code, a destination register index, two source register indices, a signed 32-bit displacement and a 32-bit absolute address. The displacement also serves as the constant in immediate mode. The block computes the effective address and reads the operand over a single-port synchronous read interface. Memory-indirect mode needs two reads. The block then adds the operand to the destination register and applies any pre-decrement or post-increment update of the base register. A one-cycle `done` pulse ends every instruction, and `result` shows the value that the destination register receives.

Instructions enter over a valid/ready handshake. An instruction is taken on a rising edge where both `in_valid` and `in_ready` are high. `in_ready` drops at that edge and rises again on the edge that ends the `done` cycle. The instruction fields only need to be stable in the cycle of acceptance, and `in_valid` raised while `in_ready` is low has no effect. The memory side has no back-pressure. Each `mem_req` lasts exactly one cycle, and the block waits as long as needed for the matching `mem_rvalid`. It never has more than one read outstanding.

The register file holds 16 registers of 32 bits, and all of them reset to zero. The operand size D is a parameter with a default of 4.

Top module: `opnd_addr_unit`

## Requirements
- R1: After reset, `in_ready` is 1, `done` is 0, `mem_req` is 0 and every register reads as zero.
- R2: Mode 0 (register) adds Reg[ra] to Reg[rd], and mode 1 (immediate) adds the displacement field to Reg[rd]. Neither mode issues a memory read.
- R3: Each of these modes issues exactly one read, and its address is as follows: mode 2 (displacement) reads disp + Reg[ra], mode 3 (register indirect) reads Reg[ra], mode 4 (indexed) reads Reg[ra] + Reg[rb], and mode 5 (direct) reads the absolute address field.
- R4: Mode 6 (memory indirect) issues two reads. The first is at Reg[ra], and the second is at the data returned by the first. The operand is the data of the second read.
- R5: Mode 7 (post-increment) reads at the old Reg[ra], then sets Reg[ra] to old Reg[ra] + D.
- R6: Mode 8 (pre-decrement) sets Reg[ra] to Reg[ra] − D and reads at that new value.
- R7: Mode 9 (scaled) reads at disp + Reg[ra] + Reg[rb] × D.
- R8: In modes 7 and 8, if rd equals ra, then Reg[rd] ends as its old value plus the operand, and the base update is lost.
- R9: Mode codes 10 to 15 produce `done` together with `illegal` and no memory read, leave every register unchanged, and show the unchanged Reg[rd] on `result`.
- R10: `in_valid` asserted while `in_ready` is low starts no instruction and alters no register.
- R11: Every accepted instruction yields exactly one single-cycle `done`, during which `result` equals the new Reg[rd]. `in_ready` returns on the following cycle.
- R12: Each memory read is a single-cycle `mem_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle and able to take an instruction |
| in_mode | input | 4 | Addressing mode code (0 to 9 legal) |
| in_rd | input | 4 | Destination register index |
| in_ra | input | 4 | Base / first source register index |
| in_rb | input | 4 | Index register index |
| in_disp | input | 32 | Signed displacement or immediate constant |
| in_abs | input | 32 | Absolute address for direct mode |
| mem_req | output | 1 | Single-cycle read request |
| mem_addr | output | 32 | Read address, valid with mem_req |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle end-of-instruction pulse |
| illegal | output | 1 | With done: mode code was not legal |
| result | output | 32 | With done: new value of Reg[rd] |

## Verification
A corrupted register or a stale base shows up at the ports as a wrong `mem_addr` or a wrong `result` on the next instruction that reads that register. The bench's own register model catches this within a few instructions. A sequencer that takes a wrong turn shows up at once as the wrong number of `mem_req` pulses before `done`, such as one read in memory-indirect mode or one read in register mode, or as a `done` that never comes, which the per-instruction timeout reports. A wrong ordering of base update and read shifts the first read address by exactly D, and a wrong write priority shows as the base value instead of the sum when rd equals ra.

// File: rtl/oau_pkg.sv
package oau_pkg;

  typedef enum logic [3:0] {
    M_REG  = 4'd0,
    M_IMM  = 4'd1,
    M_DISP = 4'd2,
    M_RIND = 4'd3,
    M_IDX  = 4'd4,
    M_DIR  = 4'd5,
    M_MIND = 4'd6,
    M_AINC = 4'd7,
    M_ADEC = 4'd8,
    M_SCL  = 4'd9
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_READ1, S_READ2, S_EXEC, S_WB
  } state_e;

  localparam logic [3:0] LAST_LEGAL_MODE = 4'd9;

endpackage

// File: rtl/oau_regfile.sv
module oau_regfile #(
  parameter int XLEN  = 32,
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [XLEN-1:0]  ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [XLEN-1:0]  rb_data,
  input  logic [IDX_W-1:0] rc_idx,
  output logic [XLEN-1:0]  rc_data,
  input  logic             wa_en,
  input  logic [IDX_W-1:0] wa_idx,
  input  logic [XLEN-1:0]  wa_data,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [XLEN-1:0]  wb_data
);

  logic [XLEN-1:0] rf_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [XLEN-1:0] q;
    // port A (destination write) has priority over port B (base update)
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 q <= '0;
      else if (wa_en && wa_idx == IDX_W'(g))      q <= wa_data;
      else if (wb_en && wb_idx == IDX_W'(g))      q <= wb_data;
    end
    assign rf_q[g] = q;
  end

  assign ra_data = rf_q[ra_idx];
  assign rb_data = rf_q[rb_idx];
  assign rc_data = rf_q[rc_idx];

  assert_rd_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en && wb_en && wa_idx == wb_idx) |=> rf_q[$past(wa_idx)] == $past(wa_data));

  assert_base_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !(wa_en && wa_idx == wb_idx)) |=> rf_q[$past(wb_idx)] == $past(wb_data));

endmodule

// File: rtl/oau_ea_calc.sv
module oau_ea_calc
  import oau_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int OPND_BYTES = 4
) (
  input  logic [3:0]      mode,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] idx_val,
  input  logic [XLEN-1:0] disp,
  input  logic [XLEN-1:0] abs_addr,
  output logic [XLEN-1:0] ea,
  output logic [XLEN-1:0] new_base,
  output logic            base_upd
);

  localparam logic [XLEN-1:0] STEP = XLEN'(OPND_BYTES);

  logic [XLEN-1:0] inc_base, dec_base;
  assign inc_base = base_val + STEP;
  assign dec_base = base_val - STEP;

  always_comb begin
    ea       = '0;
    new_base = base_val;
    base_upd = 1'b0;
    case (mode)
      M_DISP: ea = disp + base_val;
      M_RIND: ea = base_val;
      M_IDX:  ea = base_val + idx_val;
      M_DIR:  ea = abs_addr;
      M_MIND: ea = base_val;
      M_AINC: begin
        ea       = base_val;
        new_base = inc_base;
        base_upd = 1'b1;
      end
      M_ADEC: begin
        ea       = dec_base;
        new_base = dec_base;
        base_upd = 1'b1;
      end
      M_SCL:  ea = disp + base_val + idx_val * STEP;
      default: ea = '0;
    endcase
  end

endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
  import oau_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int NREG       = 16,
  parameter int OPND_BYTES = 4,
  parameter int IDX_W      = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_mode,
  input  logic [IDX_W-1:0] in_rd,
  input  logic [IDX_W-1:0] in_ra,
  input  logic [IDX_W-1:0] in_rb,
  input  logic [XLEN-1:0]  in_disp,
  input  logic [XLEN-1:0]  in_abs,
  output logic             mem_req,
  output logic [XLEN-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic             done,
  output logic             illegal,
  output logic [XLEN-1:0]  result
);

  state_e            st;
  logic [3:0]        mode_q;
  logic [IDX_W-1:0]  rd_q, ra_q, rb_q;
  logic [XLEN-1:0]   disp_q, abs_q;
  logic [XLEN-1:0]   ea_q, nb_q, opnd_q, sum_q;
  logic              upd_q, pend_q;

  logic [XLEN-1:0]   rf_a, rf_b, rf_c;
  logic [XLEN-1:0]   ea_w, nb_w;
  logic              upd_w, legal;

  assign legal    = (mode_q <= LAST_LEGAL_MODE);
  assign in_ready = (st == S_IDLE);
  assign mem_req  = (st == S_READ1 || st == S_READ2) && !pend_q;
  assign mem_addr = (st == S_READ2) ? opnd_q : ea_q;
  assign done     = (st == S_WB);
  assign illegal  = (st == S_WB) && !legal;
  assign result   = sum_q;

  oau_regfile #(.XLEN(XLEN), .NREG(NREG), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(ra_q), .ra_data(rf_a),
    .rb_idx(rb_q), .rb_data(rf_b),
    .rc_idx(rd_q), .rc_data(rf_c),
    .wa_en(st == S_WB && legal), .wa_idx(rd_q), .wa_data(sum_q),
    .wb_en(st == S_WB && upd_q), .wb_idx(ra_q), .wb_data(nb_q)
  );

  oau_ea_calc #(.XLEN(XLEN), .OPND_BYTES(OPND_BYTES)) u_ea (
    .mode(mode_q), .base_val(rf_a), .idx_val(rf_b),
    .disp(disp_q), .abs_addr(abs_q),
    .ea(ea_w), .new_base(nb_w), .base_upd(upd_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mode_q <= '0;
      rd_q   <= '0;
      ra_q   <= '0;
      rb_q   <= '0;
      disp_q <= '0;
      abs_q  <= '0;
      ea_q   <= '0;
      nb_q   <= '0;
      upd_q  <= 1'b0;
      opnd_q <= '0;
      sum_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          mode_q <= in_mode;
          rd_q   <= in_rd;
          ra_q   <= in_ra;
          rb_q   <= in_rb;
          disp_q <= in_disp;
          abs_q  <= in_abs;
          st     <= S_ADDR;
        end
        S_ADDR: begin
          ea_q  <= ea_w;
          nb_q  <= nb_w;
          upd_q <= upd_w && legal;
          if (!legal) begin
            sum_q <= rf_c;
            st    <= S_WB;
          end else if (mode_q == M_REG) begin
            opnd_q <= rf_a;
            st     <= S_EXEC;
          end else if (mode_q == M_IMM) begin
            opnd_q <= disp_q;
            st     <= S_EXEC;
          end else begin
            st <= S_READ1;
          end
        end
        S_READ1, S_READ2: begin
          if (mem_req) begin
            pend_q <= 1'b1;
          end else if (mem_rvalid) begin
            pend_q <= 1'b0;
            opnd_q <= mem_rdata;
            st     <= (st == S_READ1 && mode_q == M_MIND) ? S_READ2 : S_EXEC;
          end
        end
        S_EXEC: begin
          sum_q <= rf_c + opnd_q;
          st    <= S_WB;
        end
        S_WB:    st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_req_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && in_ready));

  assert_idle_no_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!mem_req && !done));

  assert_busy_holds_instr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !done) |=> ($stable(rd_q) && $stable(ra_q) && $stable(mode_q)));

  assert_illegal_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(st == S_ADDR));

  assert_second_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_READ2) |-> ($past(mem_rvalid) && mode_q == M_MIND));

endmodule

// File: tb/tb_opnd_addr_unit.sv
module tb_opnd_addr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_mode = '0;
  logic [3:0]  in_rd = '0, in_ra = '0, in_rb = '0;
  logic [31:0] in_disp = '0, in_abs = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, illegal;
  logic [31:0] result;

  int n_cmp = 0;
  int n_bad = 0;
  int req_n = 0;
  int done_cnt = 0;
  logic [31:0] req_log [4];
  logic [31:0] m_reg [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_addr_unit dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_rd(in_rd), .in_ra(in_ra), .in_rb(in_rb),
    .in_disp(in_disp), .in_abs(in_abs),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .illegal(illegal), .result(result)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    if (a == 32'd100) return 32'd400;
    if (a == 32'd300) return 32'd600;
    return (a * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  // bench memory: one-cycle latency
  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= memf(mem_addr);
    if (mem_req) begin
      if (req_n < 4) req_log[req_n] <= mem_addr;
      req_n <= req_n + 1;
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [3:0] mode, input logic [3:0] rd,
                     input logic [3:0] ra, input logic [3:0] rb,
                     input logic [31:0] disp, input logic [31:0] absa, input bit hold_busy);
    logic [31:0] a0, a1, op, nb, res;
    int nreq;
    bit upd, ill;
    int t;
    int dc0;
    a0 = '0; a1 = '0; op = '0; nb = '0; nreq = 1; upd = 0; ill = 0;
    case (mode)
      4'd0: begin op = m_reg[ra]; nreq = 0; end
      4'd1: begin op = disp; nreq = 0; end
      4'd2: a0 = disp + m_reg[ra];
      4'd3: a0 = m_reg[ra];
      4'd4: a0 = m_reg[ra] + m_reg[rb];
      4'd5: a0 = absa;
      4'd6: begin a0 = m_reg[ra]; a1 = memf(a0); nreq = 2; end
      4'd7: begin a0 = m_reg[ra]; nb = m_reg[ra] + D; upd = 1; end
      4'd8: begin nb = m_reg[ra] - D; a0 = nb; upd = 1; end
      4'd9: a0 = disp + m_reg[ra] + m_reg[rb] * D;
      default: begin ill = 1; nreq = 0; end
    endcase
    if (nreq == 1) op = memf(a0);
    if (nreq == 2) op = memf(a1);
    res = ill ? m_reg[rd] : m_reg[rd] + op;

    @(negedge clk);
    req_n = 0;
    in_valid = 1; in_mode = mode; in_rd = rd; in_ra = ra; in_rb = rb;
    in_disp = disp; in_abs = absa;
    @(negedge clk);
    dc0 = done_cnt;
    if (hold_busy) begin
      // keep offering a different instruction while busy (R10)
      in_mode = 4'd1; in_rd = rd; in_ra = ra; in_disp = 32'h1111;
    end else begin
      in_valid = 0;
    end
    t = 0;
    while (!done && t < 100) begin
      @(negedge clk);
      t++;
    end
    in_valid = 0;
    if (t >= 100) begin
      n_cmp++; n_bad++;
      $display("FAIL %s: timeout actual=no_done expected=done", tag);
      return;
    end
    chk({tag, " result"}, result, res);
    chk({tag, " illegal"}, {31'd0, illegal}, {31'd0, ill});
    chk({tag, " R12 read count"}, req_n, nreq);
    if (nreq >= 1) chk({tag, " addr0"}, req_log[0], a0);
    if (nreq == 2) chk({tag, " addr1"}, req_log[1], a1);
    @(negedge clk);
    chk({tag, " R11 ready after done"}, {31'd0, in_ready}, 32'd1);
    if (hold_busy) begin
      repeat (6) @(negedge clk);
      chk({tag, " R10 no extra done"}, done_cnt - dc0, 1);
    end
    if (!ill) begin
      if (upd) m_reg[ra] = nb;
      m_reg[rd] = res;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 in_ready", {31'd0, in_ready}, 32'd1);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    rst_n = 1;
    run("R1 regs zero", 4'd0, 4'd0, 4'd5, 4'd0, 32'd0, 32'd0, 0);

    // worked example: r1 = 100
    run("R2 imm", 4'd1, 4'd1, 4'd0, 4'd0, 32'd100, 32'd0, 0);
    run("R3 disp", 4'd2, 4'd2, 4'd1, 4'd0, 32'd200, 32'd0, 0);
    run("R3 indirect", 4'd3, 4'd3, 4'd1, 4'd0, 32'd0, 32'd0, 0);
    run("R4 mem-indirect", 4'd6, 4'd4, 4'd1, 4'd0, 32'd0, 32'd0, 0);
    run("R2 register", 4'd0, 4'd5, 4'd2, 4'd0, 32'd0, 32'd0, 0);
    run("R3 indexed", 4'd4, 4'd6, 4'd1, 4'd2, 32'd0, 32'd0, 0);
    run("R3 direct", 4'd5, 4'd6, 4'd0, 4'd0, 32'd0, 32'd300, 0);
    run("R7 scaled", 4'd9, 4'd7, 4'd1, 4'd1, 32'hFFFF_FFF0, 32'd0, 0);
    run("R5 autoinc", 4'd7, 4'd8, 4'd1, 4'd0, 32'd0, 32'd0, 0);
    run("R5 base check", 4'd0, 4'd9, 4'd1, 4'd0, 32'd0, 32'd0, 0);
    run("R6 autodec", 4'd8, 4'd8, 4'd1, 4'd0, 32'd0, 32'd0, 0);
    run("R6 base check", 4'd0, 4'd9, 4'd1, 4'd0, 32'd0, 32'd0, 0);
    run("R8 autoinc rd==ra", 4'd7, 4'd1, 4'd1, 4'd0, 32'd0, 32'd0, 0);
    run("R8 autodec rd==ra", 4'd8, 4'd1, 4'd1, 4'd0, 32'd0, 32'd0, 0);
    run("R8 readback", 4'd0, 4'd10, 4'd1, 4'd0, 32'd0, 32'd0, 0);
    run("R9 illegal 10", 4'd10, 4'd2, 4'd2, 4'd0, 32'd5, 32'd0, 0);
    run("R9 illegal 15", 4'd15, 4'd7, 4'd7, 4'd7, 32'd5, 32'd0, 0);
    run("R9 rd unchanged", 4'd0, 4'd11, 4'd2, 4'd0, 32'd0, 32'd0, 0);
    run("R10 busy offer", 4'd6, 4'd3, 4'd1, 4'd0, 32'd0, 32'd0, 1);
    run("R10 rd unchanged", 4'd0, 4'd12, 4'd3, 4'd0, 32'd0, 32'd0, 0);

    for (int i = 0; i < 300; i++) begin
      logic [3:0] m;
      m = ($urandom % 20 == 0) ? 4'(10 + $urandom % 6) : 4'($urandom % 10);
      run("R11 random", m, 4'($urandom), 4'($urandom), 4'($urandom),
          32'($signed($urandom % 512) - 256), $urandom, ($urandom % 8) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule